// File: doc/BRIEF.md
# Core Start-Up and Supply Supervision Sequencer

This block decides when the digital core may execute. The core supply comes from an on-chip regulator that the board can switch on or off through a strap pin. The pin's sense is fixed at build time. With the regulator running, the core is held for a short settling time every time the supply becomes good and on every wake from sleep. With the regulator bypassed, a longer power-up timer runs once when the supply becomes good. Both delays are given as clock-cycle counts.

While the regulator runs, the block also watches two digital comparator outputs. A supply below the full-speed level sets a sticky low-voltage interrupt flag without stopping the core. A supply below the minimum tracking level starts a brown-out. During a brown-out the block requests a reset, records a sticky brown-out flag and keeps the core stopped until the supply has recovered. It then applies the settling delay again. Software clears either flag by writing a one. A power-on reset clears both.

Top module: `core_pwr_seq`

## Requirements
- R1: While rst_n is low, and in the cycle after it is sampled low, run_en, rst_req, bor_flag and lvd_flag are all 0.
- R2: With the regulator on, run_en first reads 1 after the (REG_START_CYC+1)-th rising edge, counting the edge that first samples vdd_ok high as edge 1.
- R3: With the regulator off, the same count is PWRUP_CYC+1 edges.
- R4: The regulator is on when reg_sel equals REG_EN_POL. With REG_EN_POL=1, reg_sel=1 turns it on. With REG_EN_POL=0, reg_sel=1 turns it off.
- R5: If vdd_ok is sampled low while the core is held or running, run_en is 0 after that edge. No flag changes. The full delay restarts from the edge that samples vdd_ok high again.
- R6: With the regulator on, a wake pulse sampled while running drops run_en after that edge and raises it again REG_START_CYC+1 edges after the wake edge. With the regulator off, wake has no effect on run_en.
- R7: With the regulator on, below_trk sampled high while held or running sets rst_req=1, bor_flag=1 and run_en=0 after that edge. rst_req stays 1 until an edge samples vdd_ok=1 and below_trk=0. The regulator settling delay then follows, counted from that edge.
- R8: With the regulator off, below_trk has no effect on run_en, rst_req or bor_flag.
- R9: With the regulator on, below_fs sampled high sets lvd_flag after that edge and leaves run_en unchanged. With the regulator off, below_fs is ignored.
- R10: clr_lvd or clr_bor sampled high clears its flag. When a set and a clear of the same flag arrive together, the set wins. Both flags survive brown-outs and supply loss, and only rst_n clears them otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| reg_sel | input | 1 | Regulator strap pin, sense set by REG_EN_POL |
| vdd_ok | input | 1 | Supply-stable comparator output |
| below_fs | input | 1 | Supply below full-speed level |
| below_trk | input | 1 | Supply below minimum tracking level |
| wake | input | 1 | Wake-from-sleep event pulse |
| clr_lvd | input | 1 | Write-one-to-clear strobe for lvd_flag |
| clr_bor | input | 1 | Write-one-to-clear strobe for bor_flag |
| run_en | output | 1 | Core may execute |
| rst_req | output | 1 | Brown-out reset request |
| bor_flag | output | 1 | Sticky brown-out flag |
| lvd_flag | output | 1 | Sticky low-voltage interrupt flag |

## Verification
Two copies of the block are built with opposite strap sense and driven from the same inputs. Every stimulus therefore runs the regulator-on path in one copy and the bypass path in the other. The start-up table varies the strap level and the number of idle cycles before vdd_ok rises. This shows that the delay follows the decoded mode and is counted from the supply edge, not from reset. Directed sequences then apply wake pulses, comparator dips, supply loss during the hold and during run, and clear strobes that coincide with a set. These show which events restart the delay, which ones one mode ignores, and which ones only one flag responds to.

// File: rtl/cps_pkg.sv
// Shared types for the core start-up sequencer.
package cps_pkg;
    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,   // supply not yet stable
        ST_HOLD  = 2'd1,   // start-up delay running
        ST_RUN   = 2'd2,   // core executing
        ST_BROWN = 2'd3    // brown-out reset asserted
    } seq_state_t;
endpackage

// File: rtl/cps_delay.sv
// Loadable down-counter that times the start-up hold.
// Assumes: load_val is the requested delay minus one; expired is high at zero.
module cps_delay #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    // Load on request, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R2
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);
endmodule

// File: rtl/cps_fsm.sv
// Sequencer state machine: supply wait, start-up hold, run, brown-out.
// Assumes: reg_on is the decoded regulator mode; expired comes from cps_delay.
module cps_fsm
    import cps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vdd_ok,
    input  logic       reg_on,
    input  logic       below_trk,
    input  logic       wake,
    input  logic       expired,
    output seq_state_t state,
    output logic       load,
    output logic       brown_evt
);
    seq_state_t nxt;
    logic       active;

    assign active = (state == ST_HOLD) || (state == ST_RUN);

    // Next-state and counter-load decode.
    always_comb begin
        nxt       = state;
        load      = 1'b0;
        brown_evt = 1'b0;
        if (active && reg_on && below_trk) begin
            nxt       = ST_BROWN;
            brown_evt = 1'b1;
        end else begin
            unique case (state)
                ST_WAIT: if (vdd_ok) begin
                    nxt  = ST_HOLD;
                    load = 1'b1;
                end
                ST_HOLD: if (!vdd_ok)     nxt = ST_WAIT;
                         else if (expired) nxt = ST_RUN;
                ST_RUN: if (!vdd_ok) nxt = ST_WAIT;
                        else if (wake && reg_on) begin
                            nxt  = ST_HOLD;
                            load = 1'b1;
                        end
                ST_BROWN: if (vdd_ok && !below_trk) begin
                    nxt  = ST_HOLD;
                    load = 1'b1;
                end
                default: nxt = ST_WAIT;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= nxt;
    end

    // R5
    run_needs_vdd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> $past(vdd_ok));
    // R7
    brown_no_direct_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BROWN) |=> (state != ST_RUN));
endmodule

// File: rtl/cps_sticky.sv
// One sticky status bit with write-one-to-clear; set beats clear.
// Assumes: only the synchronous power-on reset clears it otherwise.
module cps_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Hold the flag until cleared; a simultaneous set keeps it high.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (set_i)  flag_o <= 1'b1;
        else if (clr_i)  flag_o <= 1'b0;
    end

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    // R10
    clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/core_pwr_seq.sv
// Core start-up and supply supervision sequencer (top level).
// Decodes the regulator strap, picks the start-up delay for the mode, runs
// the sequencer state machine and keeps the two sticky status flags.
// Assumes: comparator inputs are already synchronous to clk; delays >= 1.
module core_pwr_seq
    import cps_pkg::*;
#(
    parameter bit REG_EN_POL    = 1'b1,
    parameter int REG_START_CYC = 2000,
    parameter int PWRUP_CYC     = 6400000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reg_sel,
    input  logic vdd_ok,
    input  logic below_fs,
    input  logic below_trk,
    input  logic wake,
    input  logic clr_lvd,
    input  logic clr_bor,
    output logic run_en,
    output logic rst_req,
    output logic bor_flag,
    output logic lvd_flag
);
    localparam int MAX_CYC = (REG_START_CYC > PWRUP_CYC) ? REG_START_CYC : PWRUP_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] REG_LOAD = CW'(REG_START_CYC - 1);
    localparam logic [CW-1:0] PWR_LOAD = CW'(PWRUP_CYC - 1);
    localparam int NFLAG   = 2;   // index 0: low-voltage, index 1: brown-out

    logic          reg_on;
    logic          load, expired, brown_evt;
    logic [CW-1:0] load_val;
    seq_state_t    state;
    logic [NFLAG-1:0] set_v, clr_v, flag_v;

    // Strap decode: the build option picks which pin level means "regulator on".
    generate
        if (REG_EN_POL) begin : g_pos_en
            assign reg_on = reg_sel;
        end else begin : g_pos_dis
            assign reg_on = ~reg_sel;
        end
    endgenerate

    assign load_val = reg_on ? REG_LOAD : PWR_LOAD;

    cps_delay #(.CW(CW)) u_delay (
        .clk(clk), .rst_n(rst_n), .load(load),
        .load_val(load_val), .expired(expired)
    );

    cps_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .vdd_ok(vdd_ok), .reg_on(reg_on),
        .below_trk(below_trk), .wake(wake), .expired(expired),
        .state(state), .load(load), .brown_evt(brown_evt)
    );

    assign set_v = {brown_evt, reg_on & below_fs};
    assign clr_v = {clr_bor, clr_lvd};

    generate
        for (genvar i = 0; i < NFLAG; i++) begin : g_flag
            cps_sticky u_flag (
                .clk(clk), .rst_n(rst_n), .set_i(set_v[i]),
                .clr_i(clr_v[i]), .flag_o(flag_v[i])
            );
        end
    endgenerate

    assign lvd_flag = flag_v[0];
    assign bor_flag = flag_v[1];
    assign run_en   = (state == ST_RUN);
    assign rst_req  = (state == ST_BROWN);

    // R9
    lvd_needs_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvd_flag) |-> $past(reg_on));
    // R7
    bor_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bor_flag) |-> rst_req);
    // R8
    bor_needs_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(reg_on));
endmodule

// File: tb/core_pwr_seq_bench.sv
// Bench: two sequencers with opposite strap sense share every input.
module core_pwr_seq_bench;
    localparam int REG_N = 6;
    localparam int PWR_N = 25;
    localparam int NV    = 4;
    // Start-up table: strap level, idle cycles before vdd_ok, expected edges A / B.
    localparam int VEC_PIN [NV] = '{1, 0, 1, 0};
    localparam int VEC_GAP [NV] = '{0, 0, 5, 3};
    localparam int VEC_EA  [NV] = '{7, 26, 7, 26};
    localparam int VEC_EB  [NV] = '{26, 7, 26, 7};

    logic clk = 1'b0;
    logic rst_n, reg_sel, vdd_ok, below_fs, below_trk, wake, clr_lvd, clr_bor;
    logic run_a, req_a, bor_a, lvd_a;
    logic run_b, req_b, bor_b, lvd_b;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    core_pwr_seq #(.REG_EN_POL(1'b1), .REG_START_CYC(REG_N), .PWRUP_CYC(PWR_N)) u_core_pwr_seq (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .vdd_ok(vdd_ok),
        .below_fs(below_fs), .below_trk(below_trk), .wake(wake),
        .clr_lvd(clr_lvd), .clr_bor(clr_bor),
        .run_en(run_a), .rst_req(req_a), .bor_flag(bor_a), .lvd_flag(lvd_a)
    );

    core_pwr_seq #(.REG_EN_POL(1'b0), .REG_START_CYC(REG_N), .PWRUP_CYC(PWR_N)) u_core_pwr_seq_neg (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .vdd_ok(vdd_ok),
        .below_fs(below_fs), .below_trk(below_trk), .wake(wake),
        .clr_lvd(clr_lvd), .clr_bor(clr_bor),
        .run_en(run_b), .rst_req(req_b), .bor_flag(bor_b), .lvd_flag(lvd_b)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Inputs change at the falling edge; outputs are read 1 ns after a rising edge.
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic to_neg();
        @(negedge clk);
    endtask

    // Counts rising edges until each run_en reads 1 (edge 1 samples the stimulus).
    task automatic measure(output int ea, output int eb);
        ea = -1; eb = -1;
        for (int n = 1; n <= 200; n++) begin
            step();
            if (run_a && ea < 0) ea = n;
            if (run_b && eb < 0) eb = n;
            if (ea >= 0 && eb >= 0) break;
        end
    endtask

    task automatic do_reset(input logic pin);
        to_neg();
        rst_n = 1'b0; reg_sel = pin; vdd_ok = 1'b0; below_fs = 1'b0;
        below_trk = 1'b0; wake = 1'b0; clr_lvd = 1'b0; clr_bor = 1'b0;
        repeat (3) step();
        to_neg();
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int ea, eb;
        do_reset(1'b1);
        // R1: reset state on both copies.
        check("R1", "run_en A", run_a, 0);
        check("R1", "rst_req A", req_a, 0);
        check("R1", "bor_flag A", bor_a, 0);
        check("R1", "lvd_flag A", lvd_a, 0);
        check("R1", "run_en B", run_b, 0);

        // R2 R3 R4: start-up table.
        for (int v = 0; v < NV; v++) begin
            do_reset(logic'(VEC_PIN[v]));
            for (int g = 0; g < VEC_GAP[v]; g++) begin
                step();
                check("R2", "run_en before vdd", run_a | run_b, 0);
            end
            to_neg(); vdd_ok = 1'b1;
            measure(ea, eb);
            check(VEC_PIN[v] ? "R2" : "R3", "start-up edges A", ea, VEC_EA[v]);
            check(VEC_PIN[v] ? "R3" : "R2", "start-up edges B", eb, VEC_EB[v]);
            check("R4", "polarity A/B differ", int'(ea != eb), 1);
        end

        // Running set-up: A regulator on, B bypassed.
        do_reset(1'b1);
        vdd_ok = 1'b1;
        measure(ea, eb);

        // R9: low-voltage warning.
        to_neg(); below_fs = 1'b1;
        step();
        check("R9", "lvd A set", lvd_a, 1);
        check("R9", "lvd B ignored", lvd_b, 0);
        check("R9", "run A kept", run_a, 1);
        // R10: clear together with set keeps flag; clear alone drops it.
        to_neg(); clr_lvd = 1'b1;
        step();
        check("R10", "set wins lvd", lvd_a, 1);
        to_neg(); below_fs = 1'b0;
        step();
        check("R10", "w1c lvd", lvd_a, 0);
        to_neg(); clr_lvd = 1'b0;

        // R6: wake pulse.
        wake = 1'b1;
        step();
        check("R6", "wake drops A", run_a, 0);
        check("R6", "wake ignored B", run_b, 1);
        to_neg(); wake = 1'b0;
        ea = 1;
        for (int n = 2; n <= 40; n++) begin
            step();
            if (run_a) begin ea = n; break; end
        end
        check("R6", "wake hold edges A", ea, REG_N + 1);

        // R7 R8 R10: brown-out while lvd flag is set.
        to_neg(); below_fs = 1'b1;
        to_neg(); below_fs = 1'b0; below_trk = 1'b1;
        step();
        check("R7", "rst_req A", req_a, 1);
        check("R7", "bor A", bor_a, 1);
        check("R7", "run A low", run_a, 0);
        check("R8", "run B kept", run_b, 1);
        check("R8", "rst_req B", req_b, 0);
        check("R8", "bor B", bor_b, 0);
        repeat (3) step();
        check("R7", "rst_req held", req_a, 1);
        check("R10", "lvd survives brown-out", lvd_a, 1);
        to_neg(); below_trk = 1'b0;
        measure(ea, eb);
        check("R7", "recovery edges A", ea, REG_N + 1);
        check("R7", "rst_req released", req_a, 0);
        check("R10", "bor sticky after recovery", bor_a, 1);
        to_neg(); clr_bor = 1'b1;
        step();
        check("R10", "w1c bor", bor_a, 0);
        check("R10", "lvd unaffected", lvd_a, 1);
        to_neg(); clr_bor = 1'b0;

        // R5: supply loss while running, then during the hold.
        vdd_ok = 1'b0;
        step();
        check("R5", "loss drops A", run_a, 0);
        check("R5", "loss drops B", run_b, 0);
        check("R5", "no bor", bor_a, 0);
        to_neg(); vdd_ok = 1'b1;
        repeat (3) step();
        to_neg(); vdd_ok = 1'b0;
        to_neg(); vdd_ok = 1'b1;
        measure(ea, eb);
        check("R5", "full restart A", ea, REG_N + 1);
        check("R5", "full restart B", eb, PWR_N + 1);

        // R1: power-on reset clears sticky flags.
        to_neg(); rst_n = 1'b0;
        step();
        check("R1", "reset clears lvd", lvd_a, 0);
        check("R1", "reset drops run", run_a, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule